// File: doc/BRIEF.md
# Long Transport Test Pattern Generator

This block produces the repeating long test pattern used to exercise the transport layer of a multi-lane serial converter link. Each output beat is one frame. A frame carries M converters times S samples, and each sample is a 16-bit word that holds N data bits and CS control bits. The content depends on where the frame sits within the period:

- The first frame tags every sample with its converter ID.
- The second frame tags every sample with its sample position.
- Every later frame carries mid-scale.
- A single control bit walks across all samples, one per frame.

The period is the number of frames needed for the tagged frames plus one walk, rounded up to a multiple of the multiframe length K.

The pattern starts on a pulse that marks the end of the lane alignment sequence. It repeats for as long as the link-running flag stays high. Frames go out as a flat sample array with a valid flag and the index of the frame within the period. Two links built with the same parameters, including the same converter ID base, produce identical patterns. A link whose converter numbering does not start at zero sets `CID_BASE` to its first ID.

Top module: `ltp_gen`

## Requirements
- R1: The frame index counts 0, 1, ... up to LEN−1 and then wraps to 0, one step per clock while the pattern runs. LEN = K × ceil((M×S + 2) / K).
- R2: In frame 0, every sample of converter c carries data value CID_BASE + c + 1.
- R3: In frame 1, sample s of every converter carries data value s + 1.
- R4: In frames 2 to LEN−1, every sample carries data value 2^(N−1).
- R5: When CS > 0 and frame i < M×S, exactly one control flag is 1: the one on sample (i mod S) of converter floor(i / S), which is flat sample position c×S+s = i. The flag is bit 15−N of the word, the topmost control bit.
- R6: When CS > 0, every control bit is 0 in frames M×S to LEN−1, and control bits below the topmost are always 0.
- R7: Word layout: the data value sits in bits [15:16−N], the CS control bits follow directly below it, and all remaining low bits are 0. Sample (c, s) occupies bits [(c×S+s)×16 +: 16] of the sample bus.
- R8: A start pulse seen at a clock edge while the link is up makes the next beat valid frame 0. This also applies while a pattern is already running, in which case the pattern restarts.
- R9: While the link-running flag is low, valid is 0 and the frame index is 0 after the next edge. A start pulse is ignored while the link is down. Raising the link flag alone does not resume the pattern.
- R10: Whenever valid is 0, the sample bus and the frame index are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alignDone | input | 1 | One-cycle pulse at the end of the lane alignment sequence |
| linkUp | input | 1 | High while the link is running |
| frameValid | output | 1 | Current beat carries a pattern frame |
| frameIdx | output | IDX_W | Position of the frame within the period |
| samples | output | M×S×16 | Flat sample array, converter-major |

## Verification
The assertions assume that `linkUp` and `alignDone` change only away from the rising clock edge. They also assume that N + CS never exceeds 16 and that LEN fits within `IDX_W` bits. The stimulus drives every input on the falling edge. It only uses parameter sets that meet these limits, with periods of 5, 6 and 8 frames. The stimulus issues start pulses in three situations: while the link is down, while the link is idle, and in the middle of a running period. Each of these stays within the single-cycle pulse shape that the control logic expects.

// File: rtl/ltp_pkg.sv
package ltp_pkg;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic        valid;
    logic        frame0;
    logic        frame1;
    logic        ctlHit;
    logic [15:0] ctlPos;
  } ltp_strobe_t;

  function automatic int ceilDiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/ltp_ctrl.sv
module ltp_ctrl #(
  parameter int M     = 2,
  parameter int S     = 2,
  parameter int CS    = 1,
  parameter int K     = 4,
  parameter int IDX_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alignDone,
  input  logic                linkUp,
  output logic [IDX_W-1:0]    frameIdx,
  output ltp_pkg::ltp_strobe_t strobe
);
  localparam int WALK = M * S;
  localparam int LEN  = K * ltp_pkg::ceilDiv(WALK + 2, K);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LEN - 1);

  logic             running;
  logic [IDX_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (!linkUp) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (alignDone) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (running) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  always_comb begin
    strobe.valid  = running;
    strobe.frame0 = running && (cnt == '0);
    strobe.frame1 = running && (cnt == IDX_W'(1));
    strobe.ctlHit = running && (CS > 0) && (cnt < IDX_W'(WALK));
    strobe.ctlPos = 16'(cnt);
  end

  assign frameIdx = cnt;

  // R1
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  // R1
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && linkUp && !alignDone && cnt == LAST) |=> (cnt == '0 && running));
  // R8
  start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (linkUp && alignDone) |=> (running && cnt == '0));
  // R9
  link_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !linkUp |=> (!running && cnt == '0));
endmodule

// File: rtl/ltp_datapath.sv
module ltp_datapath #(
  parameter int M        = 2,
  parameter int S        = 2,
  parameter int N        = 12,
  parameter int CS       = 1,
  parameter int CID_BASE = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ltp_pkg::ltp_strobe_t strobe,
  output logic [M*S*16-1:0]    samples
);
  localparam int NS   = M * S;
  localparam int SH   = 16 - N;
  localparam logic [15:0] MID = 16'(1 << (N - 1));

  logic [NS-1:0] ctlBits;

  for (genvar c = 0; c < M; c++) begin : g_conv
    for (genvar s = 0; s < S; s++) begin : g_samp
      localparam int FLAT = c * S + s;
      logic [15:0] dataVal;
      logic [15:0] word;

      always_comb begin
        if (strobe.frame0)      dataVal = 16'(CID_BASE + c + 1);
        else if (strobe.frame1) dataVal = 16'(s + 1);
        else                    dataVal = MID;
        word = 16'(dataVal << SH);
        if (CS > 0 && strobe.ctlHit && strobe.ctlPos == 16'(FLAT))
          word[15 - ((CS > 0) ? N : 0)] = 1'b1;
        if (!strobe.valid) word = '0;
      end

      assign samples[FLAT*16 +: 16] = word;

      if (CS > 0) begin : g_ctl
        assign ctlBits[FLAT] = samples[FLAT*16 + 15 - N];
      end else begin : g_noctl
        assign ctlBits[FLAT] = 1'b0;
      end
    end
  end

  // R5
  ctl_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctlBits));
  // R5
  ctl_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (CS > 0 && strobe.ctlHit) |-> ($countones(ctlBits) == 1));
  // R6
  ctl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.ctlHit |-> (ctlBits == '0));
  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.valid |-> (samples == '0));
endmodule

// File: rtl/ltp_gen.sv
module ltp_gen #(
  parameter int M        = 2,
  parameter int S        = 2,
  parameter int N        = 12,
  parameter int CS       = 1,
  parameter int K        = 4,
  parameter int CID_BASE = 0,
  parameter int IDX_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alignDone,
  input  logic                linkUp,
  output logic                frameValid,
  output logic [IDX_W-1:0]    frameIdx,
  output logic [M*S*16-1:0]   samples
);
  ltp_pkg::ltp_strobe_t strobe;

  ltp_ctrl #(.M(M), .S(S), .CS(CS), .K(K), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .alignDone(alignDone), .linkUp(linkUp),
    .frameIdx(frameIdx), .strobe(strobe)
  );

  ltp_datapath #(.M(M), .S(S), .N(N), .CS(CS), .CID_BASE(CID_BASE)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .samples(samples)
  );

  assign frameValid = strobe.valid;

  // R10
  idle_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frameValid |-> (frameIdx == '0));
endmodule

// File: tb/ltp_gen_tb.sv
module ltp_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alignDone = 1'b0;
  logic linkUp = 1'b0;
  always #10 clk = ~clk;

  int total = 0;
  int bad = 0;

  // config A: M=2 S=2 N=12 CS=1 K=4 CID=0 -> LEN 8
  logic av; logic [15:0] ai; logic [63:0] as;
  // config B: M=1 S=3 N=16 CS=0 K=5 CID=2 -> LEN 5
  logic bv; logic [15:0] bi; logic [47:0] bs;
  // config C: M=4 S=1 N=14 CS=2 K=3 CID=0 -> LEN 6
  logic cv; logic [15:0] ci; logic [63:0] cs;

  ltp_gen #(.M(2), .S(2), .N(12), .CS(1), .K(4), .CID_BASE(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .alignDone(alignDone), .linkUp(linkUp),
    .frameValid(av), .frameIdx(ai), .samples(as));
  ltp_gen #(.M(1), .S(3), .N(16), .CS(0), .K(5), .CID_BASE(2)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .alignDone(alignDone), .linkUp(linkUp),
    .frameValid(bv), .frameIdx(bi), .samples(bs));
  ltp_gen #(.M(4), .S(1), .N(14), .CS(2), .K(3), .CID_BASE(0)) u_dut_c (
    .clk(clk), .rst_n(rst_n), .alignDone(alignDone), .linkUp(linkUp),
    .frameValid(cv), .frameIdx(ci), .samples(cs));

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog: run did not complete");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [15:0] expWord(int n, int csb, int cid, int m, int s,
                                          int len, int t, int c, int si);
    int f = t % len;
    logic [15:0] v;
    logic [15:0] w;
    if (f == 0)      v = 16'(cid + c + 1);
    else if (f == 1) v = 16'(si + 1);
    else             v = 16'(1 << (n - 1));
    w = 16'(v << (16 - n));
    if (csb > 0 && f < m * s && f == c * s + si) w[15 - n] = 1'b1;
    return w;
  endfunction

  function automatic string reqOf(int f, int m, int s);
    if (f == 0) return "R2/R5/R7";
    if (f == 1) return "R3/R5/R7";
    if (f < m * s) return "R4/R5/R7";
    return "R4/R6/R7";
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chkDut(int d, int t);
    int m, s, n, csb, cid, len;
    logic v; logic [15:0] idx; logic [127:0] bus;
    case (d)
      0: begin m=2; s=2; n=12; csb=1; cid=0; len=8; v=av; idx=ai; bus=128'(as); end
      1: begin m=1; s=3; n=16; csb=0; cid=2; len=5; v=bv; idx=bi; bus=128'(bs); end
      default: begin m=4; s=1; n=14; csb=2; cid=0; len=6; v=cv; idx=ci; bus=128'(cs); end
    endcase
    chk("R8 valid", 64'(v), 64'(1));
    chk("R1 frame index", 64'(idx), 64'(t % len));
    for (int c = 0; c < m; c++)
      for (int si = 0; si < s; si++)
        chk(reqOf(t % len, m, s), 64'(bus[(c*s+si)*16 +: 16]),
            64'(expWord(n, csb, cid, m, s, len, t, c, si)));
  endtask

  task automatic chkIdle(string req);
    chk({req, " valid A"}, 64'(av), 64'(0));
    chk({req, " valid B"}, 64'(bv), 64'(0));
    chk({req, " valid C"}, 64'(cv), 64'(0));
    chk({req, " idx"}, 64'({ai, bi, ci}), 64'(0));
    chk({req, " R10 samples A"}, as, 64'(0));
    chk({req, " R10 samples B"}, 64'(bs), 64'(0));
    chk({req, " R10 samples C"}, cs, 64'(0));
  endtask

  // pulse start at negedge; returns at the negedge where frame 0 is visible
  task automatic pulseStart();
    alignDone = 1'b1;
    @(negedge clk);
    alignDone = 1'b0;
  endtask

  task automatic runFrames(int from, int count);
    for (int t = from; t < from + count; t++) begin
      for (int d = 0; d < 3; d++) chkDut(d, t);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chkIdle("R10 reset");
  endtask

  task automatic t_startWhileDown();
    linkUp = 1'b0;
    pulseStart();
    chkIdle("R9 start ignored while down");
    linkUp = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chkIdle("R9 link up alone");
  endtask

  task automatic t_twoPeriods();
    pulseStart();
    runFrames(0, 25);
  endtask

  task automatic t_restart();
    pulseStart();
    runFrames(0, 3);
    pulseStart();
    runFrames(0, 13);
  endtask

  task automatic t_linkDrop();
    linkUp = 1'b0;
    @(negedge clk);
    chkIdle("R9 link drop");
    @(negedge clk);
    linkUp = 1'b1;
    @(negedge clk);
    chkIdle("R9 no resume");
    pulseStart();
    runFrames(0, 9);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_startWhileDown();
    t_twoPeriods();
    t_restart();
    t_linkDrop();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule